// File: doc/BRIEF.md
# Dual-Clock FIFO with Conservative Flags

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Each pointer is 5 address bits plus one wrap bit, giving 32 storage slots. One slot is always kept free, so the usable capacity is 31 words. Each side keeps its own binary pointer and passes a Gray-coded copy of it to the other side through a two-flop synchronizer. Each side derives its flag from its own pointer and the delayed copy of the far pointer.

The flags are pessimistic. Full can stay high for a short time after the reader frees a slot. Empty can stay high for a short time after the writer stores a word. Both lags are bounded by the synchronizer depth. The block never overwrites unread data and never returns a word twice.

A single active-high reset is sampled synchronously in both clock domains. It must be held for at least two edges of each clock. While reset is held, and for a few cycles after it is released, both flags are asserted until the synchronizers carry valid pointers. The read data output is registered.

Top module: `cdc_fifo`

## Requirements
- R1: The FIFO accepts exactly 31 words. After 31 accepted writes with no reads, `wr_full` is 1.
- R2: While `rst` is 1, both `wr_full` and `rd_empty` are 1 and `rd_data` is 0. On the first write-clock cycle after release, `wr_full` is still 1. A few cycles later it falls to 0 while `rd_empty` stays 1.
- R3: A write presented while `wr_full` is 1 is dropped. It never appears at the read side, and the occupancy never exceeds 31.
- R4: A read presented while `rd_empty` is 1 is dropped. `rd_data` holds its previous value and the read pointer does not move.
- R5: Words leave in the order they were accepted, for every burst length from 1 to 31 and under concurrent writing and reading.
- R6: A read accepted at a read-clock rising edge (with `rd_en` 1 and `rd_empty` 0) places the oldest stored word on `rd_data` right after that same edge.
- R7: If the FIFO is empty and one word is written, `rd_empty` falls no later than the second read-clock rising edge after the write edge.
- R8: If the FIFO is full and one word is read, leaving one free slot, `wr_full` falls no later than the second write-clock rising edge after the read edge.
- R9: A reset applied while words are stored discards them. Afterwards the FIFO reports empty and not full, and it stores and returns new words correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Active-high reset, sampled by both clocks |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No room; writes are dropped |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Registered read word |
| rd_empty | output | 1 | Nothing to read; reads are dropped |

## Verification
The bench targets the 31-word limit with one slot held back. A design that used all 32 slots would accept the extra write and either lose a word or wrongly report itself empty. The bench also measures, in edges of the opposite clock, how long each flag lags behind the event that releases it. A synchronizer that is too deep, or a flag computed from a stale pointer, would miss the two-edge bound. Finally, the bench drives reads into an empty FIFO and writes into a full one, and applies a reset in mid-stream. A design without proper guards would move its pointer, corrupt the output word, or keep stale words after reset.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;

    // Reset sequencing state held by each clock domain.
    typedef enum logic [1:0] {
        PH_RESET,
        PH_SETTLE,
        PH_RUN
    } phase_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cdc_fifo_sync.sv
module cdc_fifo_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= '0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/cdc_fifo_ptr.sv
module cdc_fifo_ptr
    import cdc_fifo_pkg::*;
#(
    parameter int AW        = 5,
    parameter int SYNC      = 2,
    parameter bit FULL_SIDE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [AW:0] far_gray,
    output logic [AW:0] own_gray,
    output logic [AW-1:0] addr,
    output logic        fire,
    output logic        flag
);
    localparam int PW  = AW + 1;
    localparam int CAP = (1 << AW) - 1;
    localparam int CW  = $clog2(SYNC + 1);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } ptr_t;

    ptr_t          cur, nxt;
    phase_e        phase;
    logic [CW-1:0] settle;
    logic [PW-1:0] far_bin, used;
    logic          ready, limit;

    assign far_bin = PW'(gray_to_bin(32'(far_gray)));

    if (FULL_SIDE) begin : g_full
        assign used  = cur.bin - far_bin;
        assign limit = (used >= PW'(CAP));
    end else begin : g_empty
        assign used  = far_bin - cur.bin;
        assign limit = (used == '0);
    end

    assign ready = (phase == PH_RUN);
    assign flag  = ~ready | limit;
    assign fire  = req & ~flag;

    always_comb begin
        nxt.bin  = cur.bin + PW'(1);
        nxt.gray = PW'(bin_to_gray(32'(nxt.bin)));
    end

    always_ff @(posedge clk) begin
        if (rst)       cur <= '0;
        else if (fire) cur <= nxt;
    end

    // Flags held until the far pointer has passed through the synchronizer.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_RESET;
            settle <= '0;
        end else begin
            case (phase)
                PH_RESET:  begin
                    phase  <= PH_SETTLE;
                    settle <= '0;
                end
                PH_SETTLE: begin
                    settle <= settle + CW'(1);
                    if (settle == CW'(SYNC - 1)) phase <= PH_RUN;
                end
                default:   phase <= PH_RUN;
            endcase
        end
    end

    assign own_gray = cur.gray;
    assign addr     = cur.bin[AW-1:0];

    // Pointer crossings must change one bit per step (supports R7 and R8).
    p_gray_step_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(cur.gray ^ $past(cur.gray)) <= 1);

    if (FULL_SIDE) begin : g_chk_full
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
            used <= PW'(CAP));
        p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
            (flag && req) |=> $stable(cur.bin));
    end else begin : g_chk_empty
        p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
            used <= PW'(CAP));
        p_empty_blocks_r4: assert property (@(posedge clk) disable iff (rst)
            (flag && req) |=> $stable(cur.bin));
    end
endmodule

// File: rtl/cdc_fifo_mem.sv
module cdc_fifo_mem #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) slots[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= slots[raddr];
    end
endmodule

// File: rtl/cdc_fifo.sv
module cdc_fifo #(
    parameter int AW   = 5,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray, rgray_at_w, wgray_at_r;
    logic [AW-1:0] waddr, raddr;
    logic          wfire, rfire;

    cdc_fifo_ptr #(.AW(AW), .SYNC(SYNC), .FULL_SIDE(1'b1)) wside_i (
        .clk(wr_clk), .rst(rst), .req(wr_en), .far_gray(rgray_at_w),
        .own_gray(wgray), .addr(waddr), .fire(wfire), .flag(wr_full)
    );

    cdc_fifo_ptr #(.AW(AW), .SYNC(SYNC), .FULL_SIDE(1'b0)) rside_i (
        .clk(rd_clk), .rst(rst), .req(rd_en), .far_gray(wgray_at_r),
        .own_gray(rgray), .addr(raddr), .fire(rfire), .flag(rd_empty)
    );

    cdc_fifo_sync #(.W(PW), .STAGES(SYNC)) r2w_i (
        .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_at_w)
    );

    cdc_fifo_sync #(.W(PW), .STAGES(SYNC)) w2r_i (
        .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_at_r)
    );

    cdc_fifo_mem #(.AW(AW), .DW(DW)) mem_i (
        .wr_clk(wr_clk), .we(wfire), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst(rst), .re(rfire), .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/cdc_fifo_tb_top.sv
`timescale 1ns/100ps
module cdc_fifo_tb_top;
    localparam int AW  = 5;
    localparam int DW  = 8;
    localparam int CAP = 31;

    logic          wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, rd_empty;
    logic [DW-1:0] rd_data;

    int            vectors = 0, errs = 0, wedges = 0, redges = 0;
    bit            done = 1'b0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] seq = 8'h01;

    cdc_fifo #(.AW(AW), .DW(DW), .SYNC(2)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    always #4 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5.5 rd_clk = ~rd_clk;
    end
    always @(posedge wr_clk) wedges++;
    always @(posedge rd_clk) redges++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d, output bit took);
        @(negedge wr_clk);
        took    = !wr_full;
        wr_en   = 1'b1;
        wr_data = d;
        if (took) model.push_back(d);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(input string tag, output bit got);
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        got = !rd_empty;
        if (got) exp = model.pop_front();
        else     exp = rd_data;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (got) check({tag, " R6 data"}, rd_data, exp);
        else     check("R4 data held on empty read", rd_data, exp);
    endtask

    task automatic drain(input string tag);
        bit got;
        int guard = 0;
        while (model.size() > 0 && guard < 400) begin
            pop(tag, got);
            guard++;
        end
        check({tag, " drained"}, model.size(), 0);
    endtask

    task automatic fill_to(input int n);
        bit took;
        for (int i = 0; i < n; i++) begin
            push(seq, took);
            seq++;
        end
    endtask

    initial begin
        bit took, got;
        int lag, base;
        // R2: reset state
        repeat (2) @(negedge wr_clk);
        check("R2 full in reset", wr_full, 1);
        check("R2 empty in reset", rd_empty, 1);
        check("R2 data in reset", rd_data, 0);
        repeat (4) @(negedge wr_clk);
        rst = 1'b0;
        @(negedge wr_clk);
        check("R2 full just after release", wr_full, 1);
        repeat (8) @(negedge wr_clk);
        check("R2 full clears after settle", wr_full, 0);
        check("R2 empty stays after settle", rd_empty, 1);

        // R4: read while empty
        pop("R4", got);
        check("R4 empty read not accepted", got, 0);
        check("R4 still empty", rd_empty, 1);

        // R5/R6: sweep every burst length
        for (int n = 1; n <= CAP; n++) begin
            fill_to(n);
            repeat (4) @(negedge rd_clk);
            drain("R5 sweep");
            check("R5 empty after drain", rd_empty, 1);
            repeat (4) @(negedge wr_clk);
        end

        // R1/R3: capacity and dropped writes
        fill_to(CAP);
        check("R1 accepted count", model.size(), CAP);
        @(negedge wr_clk);
        check("R1 full at 31", wr_full, 1);
        push(8'hEE, took);
        check("R3 write while full dropped", took, 0);
        repeat (4) @(negedge rd_clk);
        drain("R3 content");
        repeat (6) @(negedge rd_clk);
        check("R3 no extra word", rd_empty, 1);
        repeat (6) @(negedge wr_clk);

        // R8: full release lag, one slot freed
        fill_to(CAP);
        repeat (6) @(negedge wr_clk);
        check("R8 full before read", wr_full, 1);
        @(negedge rd_clk);
        check("R8 readable", rd_empty, 0);
        begin
            logic [DW-1:0] exp;
            exp = model.pop_front();
            rd_en = 1'b1;
            @(posedge rd_clk);
            #1;
            base = wedges;
            @(negedge rd_clk);
            rd_en = 1'b0;
            check("R8 R6 data", rd_data, exp);
        end
        lag = 99;
        for (int i = 0; i < 6; i++) begin
            @(negedge wr_clk);
            if (!wr_full && lag == 99) lag = wedges - base;
        end
        check("R8 full lag within 2 edges", lag <= 2, 1);
        drain("R8 rest");
        repeat (6) @(negedge wr_clk);

        // R7: empty release lag, several clock phases
        for (int k = 0; k < 5; k++) begin
            @(negedge wr_clk);
            wr_en = 1'b1;
            wr_data = seq;
            model.push_back(seq);
            seq++;
            @(posedge wr_clk);
            #1;
            base = redges;
            @(negedge wr_clk);
            wr_en = 1'b0;
            lag = 99;
            for (int i = 0; i < 6 && lag == 99; i++) begin
                @(negedge rd_clk);
                if (!rd_empty) lag = redges - base;
            end
            check("R7 empty lag within 2 edges", lag <= 2, 1);
            drain("R7");
            repeat (3 + k) @(negedge wr_clk);
        end

        // R5: concurrent streaming
        fork
            begin
                int sent = 0;
                while (sent < 150) begin
                    push(seq, took);
                    if (took) begin
                        sent++;
                        seq++;
                    end
                end
            end
            begin
                int rcvd = 0, guard = 0;
                while (rcvd < 150 && guard < 2000) begin
                    pop("R5 stream", got);
                    if (got) rcvd++;
                    guard++;
                end
                check("R5 stream count", rcvd, 150);
            end
        join

        // R9: reset with words stored
        repeat (6) @(negedge wr_clk);
        fill_to(10);
        @(negedge wr_clk);
        rst = 1'b1;
        repeat (4) @(negedge wr_clk);
        rst = 1'b0;
        model.delete();
        repeat (8) @(negedge rd_clk);
        check("R9 empty after reset", rd_empty, 1);
        @(negedge wr_clk);
        check("R9 not full after reset", wr_full, 0);
        push(8'h5A, took);
        check("R9 write accepted", took, 1);
        repeat (4) @(negedge rd_clk);
        pop("R9", got);
        check("R9 read accepted", got, 1);
        check("R9 empty again", rd_empty, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wr_clk);
        if (!done) begin
            vectors++;
            errs++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end
endmodule